// File: doc/BRIEF.md
# Sector-Based Serial Drum DMA Controller

This controller copies one sector of 256 words between a rotating word store (the drum) and host memory each time it is started. Software first loads a host memory address together with a direction, then either names a sector and starts, or continues with the sector that follows the one just finished. The start waits until a free-running rotational position counter reaches the first word of the chosen sector. After that one word moves on each position step.

When the sector ends, the sector number advances, a done flag is set and a one-cycle interrupt request is raised. Writes toward the drum are refused by a bank of static write-lock switches. Each switch covers a group of 16 sectors. A refused write sets an error flag, but the memory address still advances. A test command returns a skip decision on done, on error, or unconditionally for the parity variant. Both memory ports read combinationally. The drum word address is the sector number followed by the word index.

Top module: `drum_sector_dma`

## Requirements
- R1: One start moves exactly 256 words. The drum address `dr_addr` is `{sector, word_index}`, with the word index running 0 to 255.
- R2: If `p` is the rotational position in the start-command cycle and `o = (sector mod 2) * 256`, the first word moves after exactly `w = o - p` position steps, with 512 added when that value is zero or negative. During that first word `rot_pos` equals `o`.
- R3: Op 1 (load sector) takes a 9-bit sector from `cmd_data[8:0]` and starts. Op 2 (continue) starts with the sector number that is already held. Both clear `done` and `err` in the next cycle.
- R4: Op 0 (load address) latches `cmd_data` as the host address and `cmd_sub[0]` as the direction, where 1 means host to drum. It starts no transfer.
- R5: In direction 0, each drum word `dr_rdata` is written to host memory (`hm_we`) at consecutive host addresses.
- R6: In direction 1, each host word `hm_rdata` (read strobe `hm_rd`) is written to the drum (`dr_we`) when the sector's lock bit is clear.
- R7: In direction 1, when `wlock[sector >> 4]` is set, no drum write occurs and `err` becomes 1.
- R8: The host address increments after every word, whether it was read, written or blocked. It wraps modulo 2^16.
- R9: At the end of a sector, the sector number increments modulo 512, `done` is set, and `irq` is high for exactly one cycle.
- R10: Op 3 (test) drives `cmd_skip` in the same cycle. With `cmd_sub` = 0 it skips if done is set. With 1 it skips if there is no error. With 2 or 3 (the parity test) it always skips.
- R11: `rot_pos` advances by one every TICK_DIV cycles (default 4) and wraps from 511 to 0.
- R12: Reset clears the sector number, host address, direction, `done` and `err`, and cancels any pending or running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 load address, 1 load sector and start, 2 continue, 3 test |
| cmd_sub | input | 2 | Direction for op 0; test select for op 3 |
| cmd_data | input | 16 | Host address or sector number |
| cmd_skip | output | 1 | Skip decision for a test command |
| wlock | input | 32 | Static write-lock switches, one per 16 sectors |
| done | output | 1 | Sector complete flag |
| err | output | 1 | Write refused by lock |
| irq | output | 1 | One-cycle completion pulse |
| rot_pos | output | 9 | Rotational word position |
| hm_addr | output | 16 | Host memory address |
| hm_rd | output | 1 | Host read strobe (toward drum) |
| hm_rdata | input | 18 | Host read data |
| hm_we | output | 1 | Host write strobe |
| hm_wdata | output | 18 | Host write data |
| dr_addr | output | 17 | Drum word address |
| dr_rdata | input | 18 | Drum read data |
| dr_we | output | 1 | Drum write strobe |
| dr_wdata | output | 18 | Drum write data |

## Verification
The completion of a sector and a done test can fall in the same cycle. The bench provokes this by issuing a done test in the exact cycle in which the 256th word is visible on the host port. In that cycle it expects no skip, because the flag has not yet been set. In the cycle after, it expects `done` and `irq` to be high. The start-command cycle can also coincide with a position step, so the bench counts position changes from the command onward and compares the count with the wait formula at both sector origins.

// File: rtl/drum_pkg.sv
package drum_pkg;

  typedef enum logic [1:0] {
    OP_LOAD_ADDR = 2'd0,
    OP_LOAD_SEC  = 2'd1,
    OP_CONTINUE  = 2'd2,
    OP_TEST      = 2'd3
  } drum_op_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_XFER = 2'd2
  } seq_state_t;

  // skip rule for the test command: 0 done, 1 no-error, 2/3 parity (always)
  function automatic logic skip_decision(logic [1:0] sel, logic done_f, logic err_f);
    logic r;
    if (sel[1])         r = 1'b1;
    else if (sel[0])    r = ~err_f;
    else                r = done_f;
    return r;
  endfunction

endpackage

// File: rtl/drum_rot_pos.sv
module drum_rot_pos #(
  parameter int TICK_DIV = 4,
  parameter int POS_W    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             tick,
  output logic [POS_W-1:0] pos
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [DW-1:0] cnt;

  assign tick = (cnt == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pos <= '0;
    end else if (tick) begin
      cnt <= '0;
      pos <= pos + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/drum_xfer_seq.sv
module drum_xfer_seq import drum_pkg::*; #(
  parameter int WIDX_W = 8,
  parameter int POS_W  = WIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_lsb,
  input  logic              tick,
  input  logic [POS_W-1:0]  pos,
  output logic              word_evt,
  output logic              last_evt,
  output logic [WIDX_W-1:0] word_idx
);
  seq_state_t state;
  logic       tgt_q;
  logic       tgt_now;
  logic [POS_W-1:0] pos_inc;
  logic [POS_W-1:0] origin;
  logic       arrive;

  assign tgt_now  = start ? start_lsb : tgt_q;
  assign pos_inc  = pos + 1'b1;
  assign origin   = {tgt_now, {WIDX_W{1'b0}}};
  assign arrive   = tick && (pos_inc == origin);
  assign word_evt = (state == SEQ_XFER) && tick;
  assign last_evt = word_evt && (word_idx == {WIDX_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      tgt_q    <= 1'b0;
      word_idx <= '0;
    end else if (start) begin
      tgt_q    <= start_lsb;
      word_idx <= '0;
      state    <= arrive ? SEQ_XFER : SEQ_WAIT;
    end else begin
      case (state)
        SEQ_WAIT: if (arrive) state <= SEQ_XFER;
        SEQ_XFER: if (tick) begin
          word_idx <= word_idx + 1'b1;
          if (last_evt) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/drum_sector_dma.sv
module drum_sector_dma import drum_pkg::*; #(
  parameter int HOST_AW  = 16,
  parameter int DATA_W   = 18,
  parameter int SEC_W    = 9,
  parameter int WIDX_W   = 8,
  parameter int LOCK_W   = 32,
  parameter int TICK_DIV = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [1:0]               cmd_sub,
  input  logic [HOST_AW-1:0]       cmd_data,
  output logic                     cmd_skip,
  input  logic [LOCK_W-1:0]        wlock,
  output logic                     done,
  output logic                     err,
  output logic                     irq,
  output logic [WIDX_W:0]          rot_pos,
  output logic [HOST_AW-1:0]       hm_addr,
  output logic                     hm_rd,
  input  logic [DATA_W-1:0]        hm_rdata,
  output logic                     hm_we,
  output logic [DATA_W-1:0]        hm_wdata,
  output logic [SEC_W+WIDX_W-1:0]  dr_addr,
  input  logic [DATA_W-1:0]        dr_rdata,
  output logic                     dr_we,
  output logic [DATA_W-1:0]        dr_wdata
);
  localparam int POS_W     = WIDX_W + 1;
  localparam int LOCK_BITS = $clog2(LOCK_W);

  logic [SEC_W-1:0]   sector_q;
  logic [HOST_AW-1:0] ma_q;
  logic               dir_wr_q;
  logic               tick;
  logic               word_evt;
  logic               last_evt;
  logic [WIDX_W-1:0]  word_idx;

  // decoded command events
  logic is_load_addr, is_load_sec, is_cont, is_test, start_evt;
  logic [SEC_W-1:0] start_sec;
  logic [LOCK_BITS-1:0] lock_sel;
  logic sec_locked, blocked_evt;

  assign is_load_addr = cmd_valid && (cmd_op == OP_LOAD_ADDR);
  assign is_load_sec  = cmd_valid && (cmd_op == OP_LOAD_SEC);
  assign is_cont      = cmd_valid && (cmd_op == OP_CONTINUE);
  assign is_test      = cmd_valid && (cmd_op == OP_TEST);
  assign start_evt    = is_load_sec || is_cont;
  assign start_sec    = is_load_sec ? cmd_data[SEC_W-1:0]
                      : (last_evt ? sector_q + 1'b1 : sector_q);

  assign lock_sel     = sector_q[SEC_W-1 -: LOCK_BITS];
  assign sec_locked   = wlock[lock_sel];
  assign blocked_evt  = word_evt && dir_wr_q && sec_locked;

  assign cmd_skip     = is_test && skip_decision(cmd_sub, done, err);

  drum_rot_pos #(.TICK_DIV(TICK_DIV), .POS_W(POS_W)) u_rot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pos(rot_pos)
  );

  drum_xfer_seq #(.WIDX_W(WIDX_W), .POS_W(POS_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(start_evt), .start_lsb(start_sec[0]),
    .tick(tick), .pos(rot_pos),
    .word_evt(word_evt), .last_evt(last_evt), .word_idx(word_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector_q <= '0;
      ma_q     <= '0;
      dir_wr_q <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (is_load_addr) begin
        ma_q     <= cmd_data;
        dir_wr_q <= cmd_sub[0];
      end else if (word_evt) begin
        ma_q <= ma_q + 1'b1;
      end

      if (is_load_sec)   sector_q <= cmd_data[SEC_W-1:0];
      else if (last_evt) sector_q <= sector_q + 1'b1;

      if (start_evt)     done <= 1'b0;
      else if (last_evt) done <= 1'b1;

      if (start_evt)        err <= 1'b0;
      else if (blocked_evt) err <= 1'b1;

      irq <= last_evt && !start_evt;
    end
  end

  assign hm_addr  = ma_q;
  assign hm_we    = word_evt && !dir_wr_q;
  assign hm_wdata = dr_rdata;
  assign hm_rd    = word_evt && dir_wr_q;
  assign dr_addr  = {sector_q, word_idx};
  assign dr_we    = word_evt && dir_wr_q && !sec_locked;
  assign dr_wdata = hm_rdata;
endmodule

// File: rtl/drum_sector_dma_chk.sv
module drum_sector_dma_chk #(
  parameter int SEC_W  = 9,
  parameter int WIDX_W = 8,
  parameter int LOCK_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    irq,
  input logic                    done,
  input logic [WIDX_W:0]         rot_pos,
  input logic                    hm_we,
  input logic                    hm_rd,
  input logic                    dr_we,
  input logic [SEC_W+WIDX_W-1:0] dr_addr,
  input logic [LOCK_W-1:0]       wlock,
  input logic                    word_evt,
  input logic [WIDX_W-1:0]       word_idx,
  input logic [SEC_W-1:0]        sector_q
);
  localparam int LOCK_BITS = $clog2(LOCK_W);
  localparam int DA_W      = SEC_W + WIDX_W;

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R9

  AST_IRQ_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done); // R9

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_pos != $past(rot_pos)) |-> (rot_pos == $past(rot_pos) + 1'b1)); // R11

  AST_FIRST_WORD_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (word_evt && word_idx == '0) |-> (rot_pos == {sector_q[0], {WIDX_W{1'b0}}})); // R2

  AST_LOCK_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dr_we |-> !wlock[dr_addr[DA_W-1 -: LOCK_BITS]]); // R7

  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !(hm_we && (hm_rd || dr_we))); // R5
endmodule

bind drum_sector_dma drum_sector_dma_chk #(
  .SEC_W(SEC_W), .WIDX_W(WIDX_W), .LOCK_W(LOCK_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .done(done), .rot_pos(rot_pos),
  .hm_we(hm_we), .hm_rd(hm_rd), .dr_we(dr_we), .dr_addr(dr_addr),
  .wlock(wlock), .word_evt(word_evt), .word_idx(word_idx), .sector_q(sector_q)
);

// File: tb/drum_sector_dma_tb.sv
module drum_sector_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [1:0]  cmd_sub = 2'd0;
  logic [15:0] cmd_data = 16'd0;
  logic        cmd_skip;
  logic [31:0] wlock = 32'h0000_0004;
  logic        done, err, irq;
  logic [8:0]  rot_pos;
  logic [15:0] hm_addr;
  logic        hm_rd, hm_we, dr_we;
  logic [17:0] hm_rdata, hm_wdata, dr_rdata, dr_wdata;
  logic [16:0] dr_addr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  function automatic logic [17:0] drum_pat(logic [16:0] a);
    return {1'b1, a ^ 17'h15A5A};
  endfunction
  function automatic logic [17:0] host_pat(logic [15:0] a);
    return {2'b01, a ^ 16'hC3C3};
  endfunction

  assign hm_rdata = host_pat(hm_addr);
  assign dr_rdata = drum_pat(dr_addr);

  drum_sector_dma u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sub(cmd_sub), .cmd_data(cmd_data), .cmd_skip(cmd_skip), .wlock(wlock),
    .done(done), .err(err), .irq(irq), .rot_pos(rot_pos),
    .hm_addr(hm_addr), .hm_rd(hm_rd), .hm_rdata(hm_rdata), .hm_we(hm_we),
    .hm_wdata(hm_wdata), .dr_addr(dr_addr), .dr_rdata(dr_rdata), .dr_we(dr_we),
    .dr_wdata(dr_wdata)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", what, act, exp);
    end
  endtask

  // per-word monitor against the expected transfer
  logic [15:0] exp_ma = 16'd0;
  int  exp_sec = 0;
  bit  exp_dir = 1'b0;
  bit  exp_lock = 1'b0;
  int  wcnt = 0;
  int  mism = 0;
  int  dwe = 0;

  always @(negedge clk) begin
    if (hm_we || hm_rd) begin
      logic [15:0] a;
      logic [16:0] da;
      a  = exp_ma + 16'(wcnt);
      da = {9'(exp_sec), 8'(wcnt)};
      if (hm_addr != a || dr_addr != da) mism++;
      if (!exp_dir) begin
        if (!hm_we || hm_wdata != drum_pat(da)) mism++;
      end else begin
        if (!hm_rd || dr_we != !exp_lock) mism++;
        if (dr_we && dr_wdata != host_pat(a)) mism++;
      end
      if (dr_we) dwe++;
      wcnt++;
    end
  end

  task automatic send(input logic [1:0] op, input logic [1:0] sub, input logic [15:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sub = sub; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic test_skip(input logic [1:0] sub, input bit exp, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_sub = sub;
    #1;
    check(cmd_skip == exp, tag, cmd_skip, exp);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // start with op 1 or 2 and follow the whole sector
  task automatic run_xfer(input logic [1:0] op, input int sec, input logic [15:0] ma,
                          input bit dir, input bit lk);
    int p0, org, w, chg, prev, guard;
    exp_sec = sec; exp_ma = ma; exp_dir = dir; exp_lock = lk;
    @(negedge clk);
    wcnt = 0; mism = 0; dwe = 0;
    cmd_valid = 1'b1; cmd_op = op; cmd_sub = 2'd0; cmd_data = 16'(sec);
    p0 = int'(rot_pos);
    org = (sec % 2) * 256;
    w = org - p0;
    if (w <= 0) w += 512;
    chg = 0; prev = p0; guard = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done == 1'b0 && err == 1'b0, "R3 start clears flags", {done, err}, 0);
    forever begin
      if (int'(rot_pos) != prev) chg++;
      prev = int'(rot_pos);
      if (hm_we || hm_rd || guard > 5000) break;
      guard++;
      @(negedge clk);
    end
    check(chg == w, "R2 position steps before first word", chg, w);
    check(int'(rot_pos) == org, "R2 position at first word", int'(rot_pos), org);
    guard = 0;
    while (!irq && guard < 5000) begin @(negedge clk); guard++; end
    check(wcnt == 256, "R1 words per sector", wcnt, 256);
    check(mism == 0, dir ? "R6 R8 host-to-drum words" : "R5 R8 drum-to-host words", mism, 0);
    check(done == 1'b1 && irq == 1'b1, "R9 done with irq", {done, irq}, 3);
    check(err == lk, "R7 error flag", err, lk);
    if (dir && lk) check(dwe == 0, "R7 no drum write when locked", dwe, 0);
    @(negedge clk);
    check(irq == 1'b0, "R9 irq single cycle", irq, 0);
  endtask

  task automatic t_reset_state();
    check(done == 0 && err == 0 && irq == 0, "R12 flags at reset", {done, err, irq}, 0);
    check(rot_pos == 9'd0, "R11 position at reset", rot_pos, 0);
  endtask

  task automatic t_rotation();
    int n, prev, guard;
    prev = int'(rot_pos);
    while (int'(rot_pos) == prev) @(negedge clk);
    prev = int'(rot_pos); n = 0;
    while (int'(rot_pos) == prev) begin @(negedge clk); n++; end
    check(n == 4, "R11 cycles per position step", n, 4);
    guard = 0;
    while (rot_pos != 9'd511 && guard < 3000) begin @(negedge clk); guard++; end
    n = 0;
    while (rot_pos == 9'd511) begin @(negedge clk); n++; end
    check(rot_pos == 9'd0 && n == 4, "R11 wrap 511 to 0", int'(rot_pos), 0);
  endtask

  task automatic t_addr_no_start();
    int s = 0;
    send(2'd0, 2'd0, 16'h0100);
    for (int i = 0; i < 2200; i++) begin
      @(negedge clk);
      if (hm_we || hm_rd || dr_we) s++;
    end
    check(s == 0 && done == 0, "R4 load address does not start", s, 0);
  endtask

  task automatic t_collision();
    int guard = 0;
    exp_ma = 16'h0500; exp_sec = 2; exp_dir = 0; exp_lock = 0;
    send(2'd0, 2'd0, 16'h0500);
    wcnt = 0; mism = 0;
    send(2'd1, 2'd0, 16'd2);
    while (!(hm_we && hm_addr == 16'h05FF && dr_addr[7:0] == 8'hFF) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_sub = 2'd0;
    #1;
    check(cmd_skip == 1'b0, "R10 done test in completion cycle", cmd_skip, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done == 1'b1 && irq == 1'b1, "R9 completion after same-cycle test", {done, irq}, 3);
  endtask

  task automatic t_reset_midway();
    int guard = 0, s = 0;
    send(2'd0, 2'd0, 16'h0300);
    send(2'd1, 2'd0, 16'd4);
    while (wcnt < 20 && guard < 5000) begin @(negedge clk); guard++; end
    pulse_reset();
    check(done == 0 && err == 0, "R12 flags after reset", {done, err}, 0);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (hm_we || hm_rd || dr_we) s++;
    end
    check(s == 0, "R12 transfer cancelled", s, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_rotation();
    t_addr_no_start();
    run_xfer(2'd1, 6, 16'h0100, 0, 0);
    test_skip(2'd0, 1'b1, "R10 done test skips");
    test_skip(2'd1, 1'b1, "R10 error test skips without error");
    run_xfer(2'd2, 7, 16'h0200, 0, 0);
    send(2'd0, 2'd1, 16'hFF80);
    run_xfer(2'd1, 16, 16'hFF80, 1, 0);
    send(2'd0, 2'd1, 16'h0040);
    run_xfer(2'd1, 37, 16'h0040, 1, 1);
    test_skip(2'd1, 1'b0, "R10 error test no skip with error");
    test_skip(2'd2, 1'b1, "R10 parity test always skips");
    pulse_reset();
    check(done == 0 && err == 0, "R12 reset clears done and error", {done, err}, 0);
    send(2'd0, 2'd0, 16'h0010);
    run_xfer(2'd1, 511, 16'h0010, 0, 0);
    run_xfer(2'd2, 0, 16'h0110, 0, 0);
    t_collision();
    t_reset_midway();
    run_xfer(2'd2, 0, 16'h0000, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule